// File: doc/BRIEF.md
# Linked Descriptor Transmit DMA Engine

This block moves outgoing packets from system memory to a byte-wide MAC transmit stream. Software places descriptors in memory, each 32 bytes long and linked to the next one by an explicit pointer, so that they form a ring. Each descriptor carries three words: a buffer address, a config word made of an ownership (empty) flag and a byte count, and the address of the next descriptor. Software hands a descriptor to the engine by clearing its empty flag and writing the length. It then sets the enable bit in the control register.

Once enabled, the engine walks the list through a single-word read/write memory master. For each descriptor it reads the words it needs and streams the packet bytes in address order. It then writes the config word back with the empty flag set, which returns the descriptor to software, and moves on to the next pointer. When it fetches a descriptor that is still empty, it clears its own enable bit and waits, with its pointer register left on that descriptor. Software re-enables it once it has refilled the ring. To stop the engine, software writes 0 to the control register and polls until the register reads back 0.

Top module: `tdma_tx_engine`

## Requirements
- R1: After reset the control, pointer and status registers read 0, `mem_req` is low and `tx_valid` is low.
- R2: A descriptor at address P holds its buffer address at P+0, its config word at P+4 and its next pointer at P+8. In the config word, bit 31 is the empty flag and bits 11:0 are the byte length.
- R3: When the engine fetches a config word with bit 31 set, it reads no other word, writes nothing and sends no byte. It clears its enable bit and leaves the pointer register on that descriptor, so that the control register reads 0.
- R4: For a descriptor with length L > 0, byte k of the stream (k = 0..L-1) is the byte at buffer address + k. Bits 1:0 of the buffer address are treated as 0. Within a 32-bit word, the byte at the lowest address sits in bits 7:0. `tx_last` is high only on byte L-1.
- R5: After the last byte of a descriptor, the engine writes the config word back at P+4 with bit 31 set and bits 30:0 unchanged. It makes exactly one write per descriptor sent.
- R6: After each write-back, the pointer register takes the descriptor's next pointer. The engine keeps going until it reaches an empty descriptor.
- R7: The status register sets bit 0 for every packet sent and clears it when 1 is written to bit 0; writing 0 has no effect. Bits 31:16 count the packets sent, modulo 2^16, and are not cleared.
- R8: When software writes 0 to the control register, a packet already in its data phase completes, including its write-back. The control register reads 1 until then and 0 afterwards. A descriptor whose config fetch ends while the engine is disabled is neither sent nor written.
- R9: A descriptor with length 0 sends no byte and produces no `tx_last`, but it is still written back and counted.
- R10: Writes to the pointer register are ignored while the control register reads 1.
- R11: `mem_req` stays high with stable address, direction and write data until `mem_ack`. `tx_valid` stays high with stable `tx_data` and `tx_last` until `tx_ready`.
- R12: The control register sits at offset 0x180 (bit 0 enable), the pointer register at 0x184 and the status register at 0x188. Any other offset reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a packet |
| tx_ready | input | 1 | MAC accepts the byte |

## Verification
The assertions check on every cycle the signal-level rules:
- the memory and transmit handshakes hold steady until accepted;
- every memory write carries the empty flag;
- the byte count between `tx_last` pulses equals the descriptor length;
- the pointer register stays put while the engine is busy;
- the engine is idle the cycle after it meets an empty descriptor.

Only the bench scenarios can show the things that depend on memory contents and software timing:
- the byte order and the masking of an unaligned buffer address;
- that the config bits other than the empty flag are kept;
- that the walk follows non-sequential next pointers and stops on an empty descriptor;
- the stop-in-flight behaviour and the resume point, and the clear-by-writing-1 status bit.

// File: rtl/tdma_pkg.sv
`timescale 1ns/1ps
package tdma_pkg;
  localparam int WORD_W         = 32;
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int EMPTY_BIT      = 31;

  // word index of each descriptor field
  localparam logic [1:0] F_BUF = 2'd0;
  localparam logic [1:0] F_CFG = 2'd1;
  localparam logic [1:0] F_NXT = 2'd2;

  typedef enum logic [2:0] {
    W_IDLE, W_CFG, W_BUF, W_NXT, W_DATA, W_DRAIN, W_WB
  } walk_state_t;

  // byte address of a descriptor field
  function automatic logic [WORD_W-1:0] field_addr(input logic [WORD_W-1:0] base,
                                                   input logic [1:0] idx);
    return base + {{(WORD_W-4){1'b0}}, idx, 2'b00};
  endfunction

  // bytes taken from the next buffer word given the bytes still to send
  function automatic logic [2:0] chunk_len(input logic [15:0] remain);
    return (remain >= 16'(BYTES_PER_WORD)) ? 3'(BYTES_PER_WORD) : remain[2:0];
  endfunction
endpackage

// File: rtl/tdma_regs.sv
`timescale 1ns/1ps
module tdma_regs
  import tdma_pkg::*;
#(
  parameter int REG_AW   = 9,
  parameter int CNT_W    = 16,
  parameter int CTRL_OFS = 'h180,
  parameter int PTR_OFS  = 'h184,
  parameter int STAT_OFS = 'h188
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              run_en,
  output logic [WORD_W-1:0] desc_ptr,
  input  logic              core_busy,
  input  logic              stop_evt,
  input  logic              adv_evt,
  input  logic [WORD_W-1:0] adv_ptr,
  input  logic              sent_evt
);
  localparam int CNT_LSB = 16;

  logic             stat_flag;
  logic [CNT_W-1:0] pkt_cnt;
  logic             hit_ctrl, hit_ptr, hit_stat, engine_active;

  assign hit_ctrl      = (reg_addr == REG_AW'(CTRL_OFS));
  assign hit_ptr       = (reg_addr == REG_AW'(PTR_OFS));
  assign hit_stat      = (reg_addr == REG_AW'(STAT_OFS));
  assign engine_active = run_en | core_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en    <= 1'b0;
      desc_ptr  <= '0;
      stat_flag <= 1'b0;
      pkt_cnt   <= '0;
    end else begin
      if (reg_we && hit_ctrl)  run_en <= reg_wdata[0];
      else if (stop_evt)       run_en <= 1'b0;

      if (adv_evt)                                    desc_ptr <= adv_ptr;
      else if (reg_we && hit_ptr && !engine_active)   desc_ptr <= reg_wdata;

      if (sent_evt)                                   stat_flag <= 1'b1;
      else if (reg_we && hit_stat && reg_wdata[0])    stat_flag <= 1'b0;

      if (sent_evt) pkt_cnt <= pkt_cnt + 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl)      reg_rdata[0] = engine_active;
    else if (hit_ptr)  reg_rdata    = desc_ptr;
    else if (hit_stat) begin
      reg_rdata[0]                = stat_flag;
      reg_rdata[CNT_LSB +: CNT_W] = pkt_cnt;
    end
  end

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_busy && !adv_evt) |=> $stable(desc_ptr));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sent_evt |=> stat_flag);
endmodule

// File: rtl/tdma_walker.sv
`timescale 1ns/1ps
module tdma_walker
  import tdma_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [WORD_W-1:0] desc_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              ser_busy,
  output logic              ser_load,
  output logic [WORD_W-1:0] ser_word,
  output logic [2:0]        ser_nbytes,
  output logic              ser_last,
  output logic              busy,
  output logic              stop_evt,
  output logic              adv_evt,
  output logic [WORD_W-1:0] adv_ptr,
  output logic              sent_evt,
  output logic [LEN_W-1:0]  pkt_len
);
  walk_state_t       st;
  logic [WORD_W-1:0] cur, bufp, nxt, cfg;
  logic [LEN_W-1:0]  remain;
  logic [2:0]        chunk;

  assign chunk = chunk_len(16'(remain));

  always_comb begin
    mem_req   = (st == W_CFG) || (st == W_BUF) || (st == W_NXT) ||
                (st == W_DATA) || (st == W_WB);
    mem_we    = (st == W_WB);
    mem_wdata = {1'b1, cfg[WORD_W-2:0]};
    case (st)
      W_BUF:   mem_addr = field_addr(cur, F_BUF);
      W_NXT:   mem_addr = field_addr(cur, F_NXT);
      W_DATA:  mem_addr = bufp;
      default: mem_addr = field_addr(cur, F_CFG);
    endcase
  end

  assign stop_evt   = (st == W_CFG) && mem_ack && mem_rdata[EMPTY_BIT];
  assign sent_evt   = (st == W_WB) && mem_ack;
  assign adv_evt    = sent_evt;
  assign adv_ptr    = nxt;
  assign ser_load   = (st == W_DATA) && mem_ack;
  assign ser_word   = mem_rdata;
  assign ser_nbytes = chunk;
  assign ser_last   = (remain <= LEN_W'(BYTES_PER_WORD));
  assign busy       = (st != W_IDLE);
  assign pkt_len    = cfg[LEN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      cur    <= '0;
      bufp   <= '0;
      nxt    <= '0;
      cfg    <= '0;
      remain <= '0;
    end else begin
      case (st)
        W_IDLE: if (run_en) begin
          cur <= desc_ptr;
          st  <= W_CFG;
        end
        W_CFG: if (mem_ack) begin
          cfg <= mem_rdata;
          st  <= (mem_rdata[EMPTY_BIT] || !run_en) ? W_IDLE : W_BUF;
        end
        W_BUF: if (mem_ack) begin
          bufp <= {mem_rdata[WORD_W-1:2], 2'b00};
          st   <= W_NXT;
        end
        W_NXT: if (mem_ack) begin
          nxt    <= mem_rdata;
          remain <= cfg[LEN_W-1:0];
          st     <= (cfg[LEN_W-1:0] == '0) ? W_WB : W_DATA;
        end
        W_DATA: if (mem_ack) begin
          remain <= remain - LEN_W'(chunk);
          bufp   <= bufp + WORD_W'(BYTES_PER_WORD);
          st     <= W_DRAIN;
        end
        W_DRAIN: if (!ser_busy) st <= (remain == '0) ? W_WB : W_DATA;
        W_WB: if (mem_ack) begin
          cur <= nxt;
          st  <= run_en ? W_CFG : W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5
  wb_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[EMPTY_BIT]);

  // R4
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> !ser_busy);

  // R3
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy);
endmodule

// File: rtl/tdma_byte_out.sv
`timescale 1ns/1ps
module tdma_byte_out
  import tdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [2:0]        load_cnt,
  input  logic              load_last,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              busy
);
  logic [WORD_W-1:0] sh;
  logic [2:0]        left;
  logic              last_q;

  assign tx_valid = (left != 3'd0);
  assign tx_data  = sh[7:0];
  assign tx_last  = last_q && (left == 3'd1);
  assign busy     = tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      left   <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      sh     <= load_word;
      left   <= load_cnt;
      last_q <= load_last;
    end else if (tx_valid && tx_ready) begin
      sh   <= sh >> 8;
      left <= left - 3'd1;
    end
  end

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
endmodule

// File: rtl/tdma_tx_engine.sv
`timescale 1ns/1ps
module tdma_tx_engine
  import tdma_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int CNT_W    = 16,
  parameter int REG_AW   = 9,
  parameter int CTRL_OFS = 'h180,
  parameter int PTR_OFS  = 'h184,
  parameter int STAT_OFS = 'h188
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  logic              run_en, core_busy, stop_evt, adv_evt, sent_evt;
  logic [WORD_W-1:0] desc_ptr, adv_ptr, ser_word;
  logic              ser_load, ser_last, ser_busy;
  logic [2:0]        ser_nbytes;
  logic [LEN_W-1:0]  pkt_len;

  tdma_regs #(
    .REG_AW(REG_AW), .CNT_W(CNT_W),
    .CTRL_OFS(CTRL_OFS), .PTR_OFS(PTR_OFS), .STAT_OFS(STAT_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .run_en(run_en), .desc_ptr(desc_ptr), .core_busy(core_busy),
    .stop_evt(stop_evt), .adv_evt(adv_evt), .adv_ptr(adv_ptr), .sent_evt(sent_evt)
  );

  tdma_walker #(.LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .desc_ptr(desc_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ser_busy(ser_busy), .ser_load(ser_load), .ser_word(ser_word),
    .ser_nbytes(ser_nbytes), .ser_last(ser_last),
    .busy(core_busy), .stop_evt(stop_evt), .adv_evt(adv_evt), .adv_ptr(adv_ptr),
    .sent_evt(sent_evt), .pkt_len(pkt_len)
  );

  tdma_byte_out u_out (
    .clk(clk), .rst_n(rst_n),
    .load(ser_load), .load_word(ser_word), .load_cnt(ser_nbytes), .load_last(ser_last),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .busy(ser_busy)
  );

  // beat counter for the length checker
  logic [LEN_W-1:0] beat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_cnt <= '0;
    else if (tx_valid && tx_ready) beat_cnt <= tx_last ? '0 : beat_cnt + 1'b1;
  end

  // R4
  pkt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |-> (LEN_W'(beat_cnt + 1'b1) == pkt_len));
endmodule

// File: tb/tdma_tx_engine_test.sv
`timescale 1ns/1ps
module tdma_tx_engine_test;
  localparam logic [8:0] A_CTRL = 9'h180;
  localparam logic [8:0] A_PTR  = 9'h184;
  localparam logic [8:0] A_STAT = 9'h188;
  localparam int MEM_WORDS = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  always #2.5 clk = ~clk;

  tdma_tx_engine uut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  logic [31:0] mem [0:MEM_WORDS-1];
  logic [7:0]  cap [$];
  int n_cmp = 0, n_mis = 0;
  int rd_cnt = 0, wr_cnt = 0, last_cnt = 0, wait_cnt = 0;
  int exp_pkts = 0;

  logic [31:0] d_addr [0:15];
  logic [31:0] d_buf  [0:15];
  logic [31:0] d_cfg0 [0:15];
  int          d_len  [0:15];

  // memory model and transmit sink, both acting away from the clock edge
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr[15:2]] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = mem[mem_addr[15:2]];
          rd_cnt++;
        end
        wait_cnt = $urandom % 3;
      end else wait_cnt--;
    end
    tx_ready = ($urandom % 4) != 0;
    if (tx_valid && tx_ready) begin
      cap.push_back(tx_data);
      if (tx_last) last_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 60000; i++) begin
      reg_read(A_CTRL, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [31:0] b, input int k);
    logic [31:0] w;
    w = mem[((b >> 2) + 32'(k / 4)) % MEM_WORDS];
    return w[(k % 4) * 8 +: 8];
  endfunction

  function automatic logic [31:0] slot_addr(input int i);
    return 32'h20 * 32'((i * 5 + 3) % 32);
  endfunction

  // lengths in d_len[0..n-1] must be set by the caller
  task automatic build_ring(input int n, input bit mis);
    for (int i = 0; i <= n; i++) d_addr[i] = slot_addr(i);
    for (int i = 0; i < n; i++) begin
      d_buf[i]  = 32'h1000 * 32'(i + 1) + (mis ? 32'($urandom % 4) : 32'h0);
      d_cfg0[i] = {1'b0, 19'($urandom), 12'(d_len[i])};
      for (int w = 0; w < (d_len[i] + 3) / 4; w++) mem[(d_buf[i] >> 2) + 32'(w)] = $urandom;
      mem[d_addr[i] >> 2]       = d_buf[i];
      mem[(d_addr[i] >> 2) + 1] = d_cfg0[i];
      mem[(d_addr[i] >> 2) + 2] = d_addr[i + 1];
      for (int p = 3; p < 8; p++) mem[(d_addr[i] >> 2) + 32'(p)] = $urandom;
    end
    d_cfg0[n] = 32'h8000_0000 | 32'($urandom % 4096);
    mem[(d_addr[n] >> 2) + 1] = d_cfg0[n];
  endtask

  task automatic clear_counts();
    rd_cnt = 0; wr_cnt = 0; last_cnt = 0;
    cap.delete();
  endtask

  task automatic check_pkt(input int i);
    int bad = 0;
    for (int k = 0; k < d_len[i]; k++) begin
      if (cap.size() == 0) bad++;
      else if (cap.pop_front() !== exp_byte(d_buf[i], k)) bad++;
    end
    chk($sformatf("R4 R2 packet %0d bytes wrong", i), bad, 0);
  endtask

  // checks descriptors first..first+cnt-1 sent, pointer on desc stop_at
  task automatic check_run(input int first, input int cnt, input int stop_at);
    logic [31:0] v;
    int nz = 0;
    for (int i = first; i < first + cnt; i++) begin
      check_pkt(i);
      if (d_len[i] != 0) nz++;
      chk($sformatf("R5 writeback desc %0d", i), mem[(d_addr[i] >> 2) + 1], d_cfg0[i] | 32'h8000_0000);
    end
    chk("R4 leftover bytes", cap.size(), 0);
    chk("R4 R9 tx_last count", last_cnt, nz);
    chk("R5 write count", wr_cnt, cnt);
    reg_read(A_PTR, v);
    chk("R6 pointer after run", v, d_addr[stop_at]);
    exp_pkts += cnt;
    reg_read(A_STAT, v);
    chk("R7 packet count", v[31:16], 32'(exp_pkts % 65536));
    if (cnt > 0) chk("R7 sent flag", v[0], 1);
    reg_read(A_CTRL, v);
    chk("R3 R8 control idle", v, 0);
  endtask

  task automatic run_ring(input int n, input bit mis);
    build_ring(n, mis);
    clear_counts();
    reg_write(A_PTR, d_addr[0]);
    reg_write(A_CTRL, 32'h1);
    wait_idle();
    check_run(0, n, n);
    chk("R3 terminator untouched", mem[(d_addr[n] >> 2) + 1], d_cfg0[n]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_mis++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 mem_req at reset", mem_req, 0);
    chk("R1 tx_valid at reset", tx_valid, 0);
    rst_n = 1'b1;
    reg_read(A_CTRL, v); chk("R1 control at reset", v, 0);
    reg_read(A_PTR, v);  chk("R1 pointer at reset", v, 0);
    reg_read(A_STAT, v); chk("R1 status at reset", v, 0);

    // R12 unmapped offsets
    reg_write(9'h18C, 32'hFFFF_FFFF);
    reg_read(9'h18C, v); chk("R12 unmapped read", v, 0);
    reg_read(9'h000, v); chk("R12 offset 0 read", v, 0);
    reg_read(A_CTRL, v); chk("R12 control unaffected", v, 0);
    reg_read(A_PTR, v);  chk("R12 pointer unaffected", v, 0);

    // R3 empty descriptor at the start pointer
    mem[(32'h200 >> 2) + 1] = 32'h8000_0ABC;
    clear_counts();
    reg_write(A_PTR, 32'h200);
    reg_write(A_CTRL, 32'h1);
    wait_idle();
    chk("R3 reads on empty", rd_cnt, 1);
    chk("R3 writes on empty", wr_cnt, 0);
    chk("R3 bytes on empty", cap.size(), 0);
    chk("R3 config unchanged", mem[(32'h200 >> 2) + 1], 32'h8000_0ABC);
    reg_read(A_PTR, v); chk("R3 pointer held", v, 32'h200);
    reg_read(A_STAT, v); chk("R7 no packet counted", v, 0);

    // directed: short lengths across word boundaries
    for (int i = 0; i < 5; i++) d_len[i] = i + 1;
    run_ring(5, 1'b0);

    // R7 clear by writing 1, writing 0 ignored
    reg_write(A_STAT, 32'h0);
    reg_read(A_STAT, v); chk("R7 write 0 keeps flag", v[0], 1);
    reg_write(A_STAT, 32'h1);
    reg_read(A_STAT, v);
    chk("R7 write 1 clears flag", v[0], 0);
    chk("R7 count kept", v[31:16], 32'(exp_pkts));

    // R9 zero length, maximum length, unaligned buffers
    d_len[0] = 0; d_len[1] = 4095; d_len[2] = 7;
    run_ring(3, 1'b1);

    // R8 stop while a packet is in flight, R10 pointer write ignored
    d_len[0] = 400; d_len[1] = 400;
    build_ring(2, 1'b0);
    clear_counts();
    reg_write(A_PTR, d_addr[0]);
    reg_write(A_CTRL, 32'h1);
    while (cap.size() < 10) @(negedge clk);
    reg_write(A_CTRL, 32'h0);
    reg_read(A_CTRL, v); chk("R8 busy after stop write", v, 1);
    reg_write(A_PTR, 32'h3E0);
    wait_idle();
    chk("R8 second descriptor untouched", mem[(d_addr[1] >> 2) + 1], d_cfg0[1]);
    check_run(0, 1, 1);
    clear_counts();
    reg_write(A_CTRL, 32'h1);
    wait_idle();
    check_run(1, 1, 2);

    // constrained random rings
    for (int r = 0; r < 6; r++) begin
      int n;
      n = 1 + int'($urandom % 5);
      for (int i = 0; i < n; i++) d_len[i] = ($urandom % 5 == 0) ? 0 : 1 + int'($urandom % 300);
      run_ring(n, 1'($urandom % 2));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule